// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor core and its first-level cache and keeps account of every memory request that has been issued but not yet answered. Requests are sorted into two classes. Plain loads and instruction fetches form the read class. Every other kind is write class: stores, both halves of a read-modify-write, load-linked, store-conditional, both halves of a locked read-modify-write, and flushes. Each class has its own table of in-flight entries, keyed by cache-line address.

When a request is presented, the block answers in the same cycle. It either issues the request or rejects it, and a rejection says whether the tracker is full or the line is already busy, so the core can retry. Completion responses name a line and a table, and they remove the matching entry. A completing locked read-modify-write read locks its line until the matching locked write completes.

Four counters record the alias rejections by class pair. An age watchdog raises a flag when any entry has waited too long.

Top module: `otrk_tracker`

## Requirements
- R1: An address is reduced to its line by dropping the low LINE_OFS bits (6 by default, a 64-byte line). Two addresses that differ only in those bits always compare as the same line.
- R2: When `outstanding` equals MAX_OUT, any request is answered with status 2 (full). No table is looked up and no alias counter moves.
- R3: While a line is locked, every request to that line is answered with status 3 (aliased), except a locked write (kind 8), and no alias counter moves. Requests to other lines are unaffected.
- R4: A write-class request (kinds 2 to 9) gets status 3 if a read to its line is pending, or else if a write to its line is pending. Otherwise it gets status 1 (issued) and enters the write table.
- R5: A read-class request (kind 0 load, kind 1 fetch) gets status 3 if a write to its line is pending, or else if a read to its line is pending. Otherwise it gets status 1 and enters the read table.
- R6: Four counters each add one per alias rejection of their class pair. The pairs are store after pending load (R4 first case), store after pending store, load after pending load, and load after pending store.
- R7: `outstanding` rises by one on each issue and falls by one on each completion that hits. A completion and an issue in the same cycle leave it unchanged. The accept decision uses the count from before that cycle's completion.
- R8: `timeout` goes high exactly WD_LIMIT clock edges after the edge that entered an entry that is still pending. It is low whenever nothing is outstanding.
- R9: The completion of a locked read (kind 7) locks its line. The completion of a locked write (kind 8) to that line unlocks it.
- R10: A completion whose line has no entry in the table it names (`cpl_is_write` 1 for the write table, 0 for the read table) raises `cpl_err` in that cycle and changes no state.
- R11: With `req_valid` low, `req_status` is 0 (idle). Status codes are 0 idle, 1 issued, 2 full and 3 aliased. All of them are combinational from the current inputs and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 4 | 0 load, 1 fetch, 2 store, 3 RMW read, 4 RMW write, 5 load-linked, 6 store-conditional, 7 locked read, 8 locked write, 9 flush |
| req_addr | input | ADDR_W | Byte address of the request |
| req_status | output | 2 | 0 idle, 1 issued, 2 full, 3 aliased |
| cpl_valid | input | 1 | A completion is presented this cycle |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_addr | input | ADDR_W | Address of the completing line |
| cpl_err | output | 1 | Completion matched no entry |
| outstanding | output | $clog2(MAX_OUT+1) | Number of requests in flight |
| timeout | output | 1 | Some entry reached the age limit |
| cnt_st_ld | output | CNT_W | Store-after-load alias count |
| cnt_st_st | output | CNT_W | Store-after-store alias count |
| cnt_ld_ld | output | CNT_W | Load-after-load alias count |
| cnt_ld_st | output | CNT_W | Load-after-store alias count |

## Verification
The bench builds the tracker with MAX_OUT=3, WD_LIMIT=12 and CNT_W=8. Three accepted requests are enough to reach the full state, including the case where a completion and a rejected request arrive in the same cycle. The age limit is short enough to step through cycle by cycle and confirm that the flag rises on the twelfth edge and not the eleventh. The vector table sends each alias class a different number of times, so a miswired counter shows up as a wrong count. The lock is set and cleared only through completions and is observed through the statuses of later requests.

// File: rtl/otrk_pkg.sv
package otrk_pkg;

  typedef enum logic [3:0] {
    K_LOAD    = 4'd0,
    K_IFETCH  = 4'd1,
    K_STORE   = 4'd2,
    K_RMW_RD  = 4'd3,
    K_RMW_WR  = 4'd4,
    K_LL      = 4'd5,
    K_SC      = 4'd6,
    K_LOCK_RD = 4'd7,
    K_LOCK_WR = 4'd8,
    K_FLUSH   = 4'd9
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_ISSUED  = 2'd1,
    S_FULL    = 2'd2,
    S_ALIASED = 2'd3
  } req_status_e;

  // alias counter slots
  localparam int A_ST_LD = 0;
  localparam int A_ST_ST = 1;
  localparam int A_LD_LD = 2;
  localparam int A_LD_ST = 3;

  function automatic logic is_write_class(input logic [3:0] kind);
    return !(kind == K_LOAD || kind == K_IFETCH);
  endfunction

endpackage

// File: rtl/otrk_table.sv
module otrk_table #(
  parameter int DEPTH     = 8,
  parameter int LINE_W    = 26,
  parameter int AGE_LIMIT = 1000,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [3:0]        ins_kind,
  input  logic [LINE_W-1:0] rm_line,
  input  logic              rm_en,
  output logic              rm_hit,
  output logic [3:0]        rm_kind,
  output logic [OCC_W-1:0]  occ,
  output logic              aged
);

  logic              vld    [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [3:0]        kind_q [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];
  logic [IDX_W-1:0]  rm_idx;
  logic [IDX_W-1:0]  free_idx;
  logic              got_free;

  always_comb begin
    look_hit = 1'b0;
    rm_hit   = 1'b0;
    rm_idx   = '0;
    rm_kind  = '0;
    free_idx = '0;
    got_free = 1'b0;
    occ      = '0;
    aged     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && line_q[i] == look_line) look_hit = 1'b1;
      if (vld[i] && line_q[i] == rm_line) begin
        rm_hit  = 1'b1;
        rm_idx  = IDX_W'(i);
        rm_kind = kind_q[i];
      end
      if (!vld[i] && !got_free) begin
        got_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      occ  = occ + OCC_W'(vld[i]);
      aged = aged | (vld[i] && age_q[i] == AGE_W'(AGE_LIMIT));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        vld[i]    <= 1'b0;
        line_q[i] <= '0;
        kind_q[i] <= '0;
        age_q[i]  <= '0;
      end else if (ins_en && free_idx == IDX_W'(i)) begin
        vld[i]    <= 1'b1;
        line_q[i] <= ins_line;
        kind_q[i] <= ins_kind;
        age_q[i]  <= '0;
      end else begin
        if (rm_en && rm_idx == IDX_W'(i)) vld[i] <= 1'b0;
        if (vld[i] && age_q[i] != AGE_W'(AGE_LIMIT)) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/otrk_alias_stats.sv
module otrk_alias_stats #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            inc,
  output logic [3:0][CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    for (int g = 0; g < 4; g++) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end

endmodule

// File: rtl/otrk_tracker.sv
module otrk_tracker
  import otrk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int MAX_OUT  = 8,
  parameter int WD_LIMIT = 1000,
  parameter int CNT_W    = 16,
  localparam int LINE_W  = ADDR_W - LINE_OFS,
  localparam int OUT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_status,
  input  logic              cpl_valid,
  input  logic              cpl_is_write,
  input  logic [ADDR_W-1:0] cpl_addr,
  output logic              cpl_err,
  output logic [OUT_W-1:0]  outstanding,
  output logic              timeout,
  output logic [CNT_W-1:0]  cnt_st_ld,
  output logic [CNT_W-1:0]  cnt_st_st,
  output logic [CNT_W-1:0]  cnt_ld_ld,
  output logic [CNT_W-1:0]  cnt_ld_st
);

  function automatic logic [LINE_W-1:0] to_line(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFS];
  endfunction

  logic [LINE_W-1:0] req_line, cpl_line;
  logic              rd_look_hit, wr_look_hit;
  logic              rd_rm_hit, wr_rm_hit;
  logic [3:0]        rd_rm_kind, wr_rm_kind, retire_kind;
  logic [OUT_W-1:0]  rd_occ, wr_occ;
  logic              rd_aged, wr_aged;
  logic              is_full, line_locked, wr_cls;
  logic              ins_rd, ins_wr, rm_rd, rm_wr;
  logic              accept, retire;
  logic [3:0]        alias_inc;
  logic              lock_vld;
  logic [LINE_W-1:0] lock_line;
  logic [3:0][CNT_W-1:0] stat_cnt;

  assign req_line    = to_line(req_addr);
  assign cpl_line    = to_line(cpl_addr);
  assign is_full     = outstanding >= OUT_W'(MAX_OUT);
  assign line_locked = lock_vld && lock_line == req_line && req_kind != K_LOCK_WR;
  assign wr_cls      = is_write_class(req_kind);

  always_comb begin
    req_status = S_IDLE;
    alias_inc  = '0;
    ins_rd     = 1'b0;
    ins_wr     = 1'b0;
    if (req_valid) begin
      if (is_full)          req_status = S_FULL;
      else if (line_locked) req_status = S_ALIASED;
      else if (wr_cls) begin
        if (rd_look_hit) begin
          req_status         = S_ALIASED;
          alias_inc[A_ST_LD] = 1'b1;
        end else if (wr_look_hit) begin
          req_status         = S_ALIASED;
          alias_inc[A_ST_ST] = 1'b1;
        end else begin
          req_status = S_ISSUED;
          ins_wr     = 1'b1;
        end
      end else begin
        if (wr_look_hit) begin
          req_status         = S_ALIASED;
          alias_inc[A_LD_ST] = 1'b1;
        end else if (rd_look_hit) begin
          req_status         = S_ALIASED;
          alias_inc[A_LD_LD] = 1'b1;
        end else begin
          req_status = S_ISSUED;
          ins_rd     = 1'b1;
        end
      end
    end
  end

  assign rm_rd       = cpl_valid && !cpl_is_write && rd_rm_hit;
  assign rm_wr       = cpl_valid && cpl_is_write && wr_rm_hit;
  assign cpl_err     = cpl_valid && !(rm_rd || rm_wr);
  assign accept      = ins_rd || ins_wr;
  assign retire      = rm_rd || rm_wr;
  assign retire_kind = rm_wr ? wr_rm_kind : rd_rm_kind;
  assign timeout     = rd_aged || wr_aged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      lock_vld    <= 1'b0;
      lock_line   <= '0;
    end else begin
      outstanding <= outstanding + OUT_W'(accept) - OUT_W'(retire);
      if (retire && retire_kind == K_LOCK_RD) begin
        lock_vld  <= 1'b1;
        lock_line <= cpl_line;
      end else if (retire && retire_kind == K_LOCK_WR && lock_line == cpl_line) begin
        lock_vld  <= 1'b0;
      end
    end
  end

  otrk_table #(.DEPTH(MAX_OUT), .LINE_W(LINE_W), .AGE_LIMIT(WD_LIMIT)) u_rd_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_look_hit),
    .ins_en(ins_rd), .ins_line(req_line), .ins_kind(req_kind),
    .rm_line(cpl_line), .rm_en(rm_rd), .rm_hit(rd_rm_hit), .rm_kind(rd_rm_kind),
    .occ(rd_occ), .aged(rd_aged)
  );

  otrk_table #(.DEPTH(MAX_OUT), .LINE_W(LINE_W), .AGE_LIMIT(WD_LIMIT)) u_wr_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_look_hit),
    .ins_en(ins_wr), .ins_line(req_line), .ins_kind(req_kind),
    .rm_line(cpl_line), .rm_en(rm_wr), .rm_hit(wr_rm_hit), .rm_kind(wr_rm_kind),
    .occ(wr_occ), .aged(wr_aged)
  );

  otrk_alias_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .inc(alias_inc), .cnt(stat_cnt)
  );

  assign cnt_st_ld = stat_cnt[A_ST_LD];
  assign cnt_st_st = stat_cnt[A_ST_ST];
  assign cnt_ld_ld = stat_cnt[A_LD_LD];
  assign cnt_ld_st = stat_cnt[A_LD_ST];

endmodule

// File: rtl/otrk_tracker_chk.sv
module otrk_tracker_chk #(
  parameter int OUT_W   = 4,
  parameter int MAX_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_status,
  input logic [OUT_W-1:0] outstanding,
  input logic [OUT_W-1:0] rd_occ,
  input logic [OUT_W-1:0] wr_occ,
  input logic             cpl_err,
  input logic             timeout,
  input logic [3:0]       alias_inc,
  input logic             locked_hit
);

  // R2
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && outstanding >= OUT_W'(MAX_OUT)) |-> req_status == 2'd2);

  // R7
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, outstanding} == ({1'b0, rd_occ} + {1'b0, wr_occ}));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_err && req_status != 2'd1) |=> $stable(outstanding));

  // R8
  timeout_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> outstanding != '0);

  // R6
  alias_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_status == 2'd3 && !locked_hit) |-> $countones(alias_inc) == 1);

  // R3
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_status != 2'd3 || locked_hit) |-> alias_inc == 4'd0);

  // R11
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_status == 2'd0);

endmodule

bind otrk_tracker otrk_tracker_chk #(.OUT_W(OUT_W), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status(req_status),
  .outstanding(outstanding), .rd_occ(rd_occ), .wr_occ(wr_occ),
  .cpl_err(cpl_err), .timeout(timeout), .alias_inc(alias_inc),
  .locked_hit(line_locked)
);

// File: tb/otrk_tracker_bench.sv
module otrk_tracker_bench;

  localparam int MAX_OUT  = 3;
  localparam int WD_LIMIT = 12;
  localparam int CNT_W    = 8;
  localparam int OUT_W    = $clog2(MAX_OUT + 1);

  localparam logic [3:0] LD = 4'd0, IF = 4'd1, ST = 4'd2, RW = 4'd4, SC = 4'd6;
  localparam logic [3:0] LR = 4'd3, KR = 4'd7, KW = 4'd8, FL = 4'd9;
  localparam logic [1:0] IDL = 2'd0, ISS = 2'd1, FUL = 2'd2, ALI = 2'd3;

  typedef struct packed {
    logic        rv;
    logic [3:0]  kind;
    logic [31:0] raddr;
    logic        cv;
    logic        cw;
    logic [31:0] caddr;
    logic [1:0]  est;
    logic        eerr;
    logic [3:0]  ecnt;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, LD, 32'h1000, 1'b0, 1'b0, 32'h0,    ISS, 1'b0, 4'd1}, // R5 issue
    '{1'b1, LD, 32'h1010, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd1}, // R1 R5 ld/ld
    '{1'b1, IF, 32'h103F, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd1}, // R1 ld/ld
    '{1'b1, ST, 32'h1008, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd1}, // R4 st/ld
    '{1'b1, ST, 32'h2000, 1'b0, 1'b0, 32'h0,    ISS, 1'b0, 4'd2}, // R4 issue
    '{1'b1, LD, 32'h2004, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2}, // R5 ld/st
    '{1'b1, LD, 32'h2030, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2},
    '{1'b1, IF, 32'h2000, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2},
    '{1'b1, LD, 32'h203C, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2},
    '{1'b1, FL, 32'h2000, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2}, // R4 st/st
    '{1'b1, SC, 32'h2010, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2},
    '{1'b1, RW, 32'h2020, 1'b0, 1'b0, 32'h0,    ALI, 1'b0, 4'd2},
    '{1'b1, IF, 32'h3000, 1'b0, 1'b0, 32'h0,    ISS, 1'b0, 4'd3},
    '{1'b1, ST, 32'h4000, 1'b0, 1'b0, 32'h0,    FUL, 1'b0, 4'd3}, // R2
    '{1'b0, LD, 32'h0,    1'b1, 1'b1, 32'h1000, IDL, 1'b1, 4'd3}, // R10 R11
    '{1'b1, LD, 32'h4000, 1'b1, 1'b0, 32'h1000, FUL, 1'b0, 4'd2}, // R2 R7
    '{1'b1, LD, 32'h1040, 1'b0, 1'b0, 32'h0,    ISS, 1'b0, 4'd3}, // R1 next line
    '{1'b0, LD, 32'h0,    1'b1, 1'b0, 32'h3004, IDL, 1'b0, 4'd2}, // R7
    '{1'b0, LD, 32'h0,    1'b1, 1'b1, 32'h2000, IDL, 1'b0, 4'd1},
    '{1'b0, LD, 32'h0,    1'b1, 1'b0, 32'h1040, IDL, 1'b0, 4'd0},
    '{1'b0, LD, 32'h0,    1'b1, 1'b0, 32'h1040, IDL, 1'b1, 4'd0}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_kind = '0;
  logic [31:0] req_addr = '0;
  logic cpl_valid = 1'b0;
  logic cpl_is_write = 1'b0;
  logic [31:0] cpl_addr = '0;
  logic [1:0] req_status;
  logic cpl_err;
  logic [OUT_W-1:0] outstanding;
  logic timeout;
  logic [CNT_W-1:0] cnt_st_ld, cnt_st_st, cnt_ld_ld, cnt_ld_st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  otrk_tracker #(.ADDR_W(32), .LINE_OFS(6), .MAX_OUT(MAX_OUT), .WD_LIMIT(WD_LIMIT),
                 .CNT_W(CNT_W)) u_otrk_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_status(req_status), .cpl_valid(cpl_valid),
    .cpl_is_write(cpl_is_write), .cpl_addr(cpl_addr), .cpl_err(cpl_err),
    .outstanding(outstanding), .timeout(timeout), .cnt_st_ld(cnt_st_ld),
    .cnt_st_st(cnt_st_st), .cnt_ld_ld(cnt_ld_ld), .cnt_ld_st(cnt_ld_st)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [3:0] kind, input logic [31:0] ra,
                      input logic cv, input logic cw, input logic [31:0] ca,
                      input logic [1:0] est, input logic eerr, input logic [3:0] ecnt,
                      input string tag);
    @(negedge clk);
    req_valid = rv; req_kind = kind; req_addr = ra;
    cpl_valid = cv; cpl_is_write = cw; cpl_addr = ca;
    #1;
    check({tag, " status"}, 32'(req_status), 32'(est));
    check({tag, " cpl_err"}, 32'(cpl_err), 32'(eerr));
    @(posedge clk);
    #1;
    check({tag, " outstanding"}, 32'(outstanding), 32'(ecnt));
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 reset status", 32'(req_status), 32'(IDL));
    check("R7 reset count", 32'(outstanding), 0);
    check("R8 reset timeout", 32'(timeout), 0);
    check("R10 reset err", 32'(cpl_err), 0);
    check("R6 reset counters", 32'({cnt_st_ld, cnt_st_st, cnt_ld_ld, cnt_ld_st}), 0);

    for (int i = 0; i < NV; i++)
      step(VEC[i].rv, VEC[i].kind, VEC[i].raddr, VEC[i].cv, VEC[i].cw, VEC[i].caddr,
           VEC[i].est, VEC[i].eerr, VEC[i].ecnt, $sformatf("R4 R5 R7 vec%0d", i));
    idle_cycle();
    check("R6 store after load", 32'(cnt_st_ld), 1);
    check("R6 store after store", 32'(cnt_st_st), 3);
    check("R6 load after load", 32'(cnt_ld_ld), 2);
    check("R6 load after store", 32'(cnt_ld_st), 4);

    // line lock set and cleared by completions
    step(1, KR, 32'h5000, 0, 0, 0, ISS, 0, 1, "R9 locked read issue");
    step(0, LD, 0, 1, 1, 32'h5000, IDL, 0, 0, "R9 locked read done");
    step(1, LD, 32'h5008, 0, 0, 0, ALI, 0, 0, "R3 load to locked line");
    step(1, LR, 32'h5000, 0, 0, 0, ALI, 0, 0, "R3 rmw read to locked line");
    step(1, LD, 32'h6000, 0, 0, 0, ISS, 0, 1, "R3 other line free");
    step(0, LD, 0, 1, 0, 32'h6000, IDL, 0, 0, "R3 other line done");
    check("R3 no counter move", 32'({cnt_st_ld, cnt_st_st, cnt_ld_ld, cnt_ld_st}),
          {8'd1, 8'd3, 8'd2, 8'd4});
    step(1, KW, 32'h5010, 0, 0, 0, ISS, 0, 1, "R3 locked write passes");
    step(0, LD, 0, 1, 1, 32'h5000, IDL, 0, 0, "R9 locked write done");
    step(1, LD, 32'h5000, 0, 0, 0, ISS, 0, 1, "R9 line unlocked");
    step(0, LD, 0, 1, 0, 32'h5000, IDL, 0, 0, "R9 load done");

    // watchdog timing
    step(1, LD, 32'h7000, 0, 0, 0, ISS, 0, 1, "R8 aging entry");
    for (int k = 1; k < WD_LIMIT; k++) begin
      idle_cycle();
      check("R8 timeout early", 32'(timeout), 0);
    end
    idle_cycle();
    check("R8 timeout at limit", 32'(timeout), 1);
    step(0, LD, 0, 1, 0, 32'h7000, IDL, 0, 0, "R8 entry done");
    check("R8 timeout clears when empty", 32'(timeout), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule